// File: doc/BRIEF.md
# Aging Memory Command Scheduler

This block holds a small pool of pending memory commands, each tagged with a requester ID, a QoS level and a read/write flag. Every cycle it chooses one command to present on its issue port. By default it aims for bandwidth: a ready read goes ahead of a pending write. Two mechanisms limit that bias. Requester QoS is compared before command type. A per-entry age counter, with a programmable step and threshold, lifts any command that has waited too long above every other rule.

Reads must not overtake a write to the same data. A read to a 64-byte line that has an older write still queued is held back until that write has issued. Commands enter through a valid/ready port and leave through a valid/ready port, one per cycle at most. DRAM timing, banks and data payloads are outside the block.

Top module: `mem_cmd_sched`

## Requirements
- R1: After reset the queue is empty, `iss_valid_o` is low and `cmd_ready_o` is high.
- R2: A command is stored at a clock edge where `cmd_valid_i` and `cmd_ready_o` are both high. `cmd_ready_o` is low exactly when all DEPTH entries are occupied. A slot freed by an issue in the same cycle does not count as free until the next cycle.
- R3: At most one command issues per cycle, at an edge where `iss_valid_o` and `iss_ready_i` are both high. The issued entry leaves the queue. The issue fields (address, write flag with 1 meaning write, QoS, ID) are those the command was accepted with.
- R4: Among non-aged eligible entries of equal QoS, any read is chosen before any write, even an older write. With a step of zero, a write can therefore wait behind a continuous read stream.
- R5: Among non-aged eligible entries, the one with the numerically higher QoS is chosen, whatever its type or arrival order.
- R6: Among non-aged eligible entries of equal QoS and type, the earliest accepted one is chosen.
- R7: An entry's 8-bit age starts at 0 when it is accepted. It then grows by `age_step_i` at every edge it stays queued, saturating at 255. An entry is aged while its age is at least `age_limit_i`. Aged eligible entries outrank every non-aged entry, and among aged entries the earliest accepted one wins.
- R8: A read whose address bits above bit 5 match those of an older queued write is not eligible until that write has issued. Reads to other lines and all writes are never held this way. While the queue holds any entry, `iss_valid_o` is high.
- R9: With `age_limit_i` equal to 0, every entry is aged and commands issue in strict arrival order, apart from the hold of R8.
- R10: While `iss_valid_o` is high and `iss_ready_i` is low, `iss_valid_o` stays high at the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| age_step_i | input | AGE_W | Increment added to each waiting entry's age per cycle |
| age_limit_i | input | AGE_W | Age at which an entry counts as aged |
| cmd_valid_i | input | 1 | Command present on the input port |
| cmd_ready_o | output | 1 | Queue has a free entry |
| cmd_addr_i | input | AW | Command byte address |
| cmd_wr_i | input | 1 | 1 = write, 0 = read |
| cmd_qos_i | input | QW | Requester priority, larger is more urgent |
| cmd_id_i | input | IW | Requester tag |
| iss_valid_o | output | 1 | A command is offered for issue |
| iss_ready_i | input | 1 | Memory port takes the offered command |
| iss_addr_o | output | AW | Issued address |
| iss_wr_o | output | 1 | Issued write flag |
| iss_qos_o | output | QW | Issued priority |
| iss_id_o | output | IW | Issued tag |

## Verification
Directed scenarios each isolate one ordering rule:
- an older write against a younger read at equal QoS
- a low-QoS read against a high-QoS write
- equal-class entries arriving in sequence
- a write that reaches its age limit before a high-QoS read arrives
- a read queued behind a write to the same line, next to a read to another line
- a zero age limit, which must give pure arrival order

A fill beyond depth while issue is stalled separates back-pressure from acceptance. Long random phases then vary the step, the limit, QoS and line reuse over a few lines. These phases mix hazards, aging and priority together, and every offered command is compared with a bench model built from the ordering rules.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int unsigned LINE_LSB = 6;  // 64-byte line
  localparam int unsigned AGE_W    = 8;
endpackage

// File: rtl/mcs_age_ctr.sv
module mcs_age_ctr #(
  parameter int unsigned AW_AGE = mcs_pkg::AGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [AW_AGE-1:0] step_i,
  input  logic [AW_AGE-1:0] limit_i,
  output logic              aged_o
);
  logic [AW_AGE-1:0] age_q;
  logic [AW_AGE:0]   sum;

  assign sum    = {1'b0, age_q} + {1'b0, step_i};
  assign aged_o = (age_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      age_q <= '0;
    else if (load_i)  age_q <= '0;
    else if (run_i)   age_q <= sum[AW_AGE] ? '1 : sum[AW_AGE-1:0];
  end

  // R7
  age_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && (&age_q)) |=> (&age_q));
  // R7
  age_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i) |=> (age_q >= $past(age_q)));
endmodule

// File: rtl/mcs_arb.sv
module mcs_arb #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned QW    = 2,
  parameter int unsigned LW    = 10
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [DEPTH-1:0]            valid_i,
  input  logic [DEPTH-1:0]            wr_i,
  input  logic [DEPTH-1:0][QW-1:0]    qos_i,
  input  logic [DEPTH-1:0][LW-1:0]    line_i,
  input  logic [DEPTH-1:0]            aged_i,
  input  logic [DEPTH-1:0][DEPTH-1:0] older_i,  // [i][j]: i arrived before j
  output logic [DEPTH-1:0]            grant_o,
  output logic                        any_o
);
  logic [DEPTH-1:0] blk, elig;

  // read held behind an older write to the same line
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      blk[i] = 1'b0;
      for (int j = 0; j < DEPTH; j++)
        if (j != i && valid_i[j] && wr_i[j] && !wr_i[i] && older_i[j][i] &&
            line_i[j] == line_i[i])
          blk[i] = 1'b1;
    end
  end

  assign elig = valid_i & ~blk;

  always_comb begin
    logic win, b;
    for (int i = 0; i < DEPTH; i++) begin
      win = elig[i];
      for (int j = 0; j < DEPTH; j++) begin
        b = 1'b1;
        if (j != i && elig[j]) begin
          if (aged_i[i] != aged_i[j])      b = aged_i[i];
          else if (aged_i[i])              b = older_i[i][j];
          else if (qos_i[i] != qos_i[j])   b = (qos_i[i] > qos_i[j]);
          else if (wr_i[i] != wr_i[j])     b = !wr_i[i];
          else                             b = older_i[i][j];
        end
        if (!b) win = 1'b0;
      end
      grant_o[i] = win;
    end
  end

  assign any_o = |grant_o;

  // R3
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  // R8
  no_deadlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|valid_i) |-> any_o);
endmodule

// File: rtl/mem_cmd_sched.sv
module mem_cmd_sched #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 16,
  parameter int unsigned QW    = 2,
  parameter int unsigned IW    = 4,
  parameter int unsigned AGE_W = mcs_pkg::AGE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AGE_W-1:0] age_step_i,
  input  logic [AGE_W-1:0] age_limit_i,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [AW-1:0]    cmd_addr_i,
  input  logic             cmd_wr_i,
  input  logic [QW-1:0]    cmd_qos_i,
  input  logic [IW-1:0]    cmd_id_i,
  output logic             iss_valid_o,
  input  logic             iss_ready_i,
  output logic [AW-1:0]    iss_addr_o,
  output logic             iss_wr_o,
  output logic [QW-1:0]    iss_qos_o,
  output logic [IW-1:0]    iss_id_o
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LW    = AW - mcs_pkg::LINE_LSB;

  logic [DEPTH-1:0]            valid_q, wr_q, aged, grant;
  logic [DEPTH-1:0][AW-1:0]    addr_q;
  logic [DEPTH-1:0][QW-1:0]    qos_q;
  logic [DEPTH-1:0][IW-1:0]    id_q;
  logic [DEPTH-1:0][LW-1:0]    line;
  logic [DEPTH-1:0][DEPTH-1:0] older_q;
  logic [IDX_W-1:0]            alloc_idx;
  logic                        push, fire, any;

  always_comb begin
    alloc_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!valid_q[i]) alloc_idx = IDX_W'(i);
  end

  assign cmd_ready_o = ~&valid_q;
  assign push        = cmd_valid_i & cmd_ready_o;
  assign fire        = any & iss_ready_i;
  assign iss_valid_o = any;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic alloc_here, leave_here;
    assign alloc_here = push && (alloc_idx == IDX_W'(g));
    assign leave_here = fire && grant[g];
    assign line[g]    = addr_q[g][AW-1:mcs_pkg::LINE_LSB];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        wr_q[g]    <= 1'b0;
        addr_q[g]  <= '0;
        qos_q[g]   <= '0;
        id_q[g]    <= '0;
      end else if (alloc_here) begin
        valid_q[g] <= 1'b1;
        wr_q[g]    <= cmd_wr_i;
        addr_q[g]  <= cmd_addr_i;
        qos_q[g]   <= cmd_qos_i;
        id_q[g]    <= cmd_id_i;
      end else if (leave_here) begin
        valid_q[g] <= 1'b0;
      end
    end

    // row g cleared on alloc of g; column g marks every live entry older
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) older_q[g] <= '0;
      else begin
        for (int j = 0; j < DEPTH; j++) begin
          if (alloc_here)                         older_q[g][j] <= 1'b0;
          else if (push && alloc_idx == IDX_W'(j)) older_q[g][j] <= valid_q[g];
        end
      end
    end

    mcs_age_ctr #(.AW_AGE(AGE_W)) u_age (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (alloc_here),
      .run_i   (valid_q[g] && !leave_here),
      .step_i  (age_step_i),
      .limit_i (age_limit_i),
      .aged_o  (aged[g])
    );
  end

  mcs_arb #(.DEPTH(DEPTH), .QW(QW), .LW(LW)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_q),
    .wr_i    (wr_q),
    .qos_i   (qos_q),
    .line_i  (line),
    .aged_i  (aged),
    .older_i (older_q),
    .grant_o (grant),
    .any_o   (any)
  );

  always_comb begin
    iss_addr_o = '0;
    iss_wr_o   = 1'b0;
    iss_qos_o  = '0;
    iss_id_o   = '0;
    for (int i = 0; i < DEPTH; i++)
      if (grant[i]) begin
        iss_addr_o = addr_q[i];
        iss_wr_o   = wr_q[i];
        iss_qos_o  = qos_q[i];
        iss_id_o   = id_q[i];
      end
  end

  // R2
  occ_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && !fire) |=> ($countones(valid_q) == $past($countones(valid_q)) + 1));
  // R3
  occ_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !push) |=> ($countones(valid_q) + 1 == $past($countones(valid_q))));
  // R10
  hold_offer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && !iss_ready_i) |=> iss_valid_o);
endmodule

// File: tb/sim_mem_cmd_sched.sv
module sim_mem_cmd_sched;
  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  age_step_i = '0, age_limit_i = 8'hFF;
  logic        cmd_valid_i = 1'b0, cmd_wr_i = 1'b0, iss_ready_i = 1'b0;
  logic [15:0] cmd_addr_i = '0;
  logic [1:0]  cmd_qos_i = '0;
  logic [3:0]  cmd_id_i = '0;
  logic        cmd_ready_o, iss_valid_o, iss_wr_o;
  logic [15:0] iss_addr_o;
  logic [1:0]  iss_qos_o;
  logic [3:0]  iss_id_o;

  always #5 clk = ~clk;

  mem_cmd_sched u0 (
    .clk_i(clk), .rst_ni(rst_ni), .age_step_i(age_step_i), .age_limit_i(age_limit_i),
    .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o), .cmd_addr_i(cmd_addr_i),
    .cmd_wr_i(cmd_wr_i), .cmd_qos_i(cmd_qos_i), .cmd_id_i(cmd_id_i),
    .iss_valid_o(iss_valid_o), .iss_ready_i(iss_ready_i), .iss_addr_o(iss_addr_o),
    .iss_wr_o(iss_wr_o), .iss_qos_o(iss_qos_o), .iss_id_o(iss_id_o)
  );

  int total = 0, fails = 0;
  bit done = 0;
  string cur_req = "R3";

  bit          m_v[D];
  int          m_seq[D], m_age[D];
  logic [15:0] m_addr[D];
  bit          m_wr[D];
  logic [1:0]  m_qos[D];
  logic [3:0]  m_id[D];
  int          seq_n = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_count();
    int c = 0;
    for (int i = 0; i < D; i++) c += m_v[i];
    return c;
  endfunction

  function automatic bit m_elig(int i);
    if (!m_v[i]) return 0;
    if (m_wr[i]) return 1;
    for (int j = 0; j < D; j++)
      if (m_v[j] && m_wr[j] && m_seq[j] < m_seq[i] && m_addr[j][15:6] == m_addr[i][15:6])
        return 0;
    return 1;
  endfunction

  function automatic bit m_beats(int i, int j);
    bit ai = (m_age[i] >= int'(age_limit_i));
    bit aj = (m_age[j] >= int'(age_limit_i));
    if (ai != aj) return ai;
    if (ai) return m_seq[i] < m_seq[j];
    if (m_qos[i] != m_qos[j]) return m_qos[i] > m_qos[j];
    if (m_wr[i] != m_wr[j]) return !m_wr[i];
    return m_seq[i] < m_seq[j];
  endfunction

  function automatic int m_winner();
    int w = -1;
    for (int i = 0; i < D; i++)
      if (m_elig(i) && (w < 0 || m_beats(i, w))) w = i;
    return w;
  endfunction

  task automatic cyc(bit push, bit wr, logic [15:0] addr, logic [1:0] qos, logic [3:0] id, bit rdy);
    int w, cnt;
    bit acc;
    @(negedge clk);
    cmd_valid_i = push; cmd_wr_i = wr; cmd_addr_i = addr; cmd_qos_i = qos; cmd_id_i = id;
    iss_ready_i = rdy;
    #1;
    cnt = m_count();
    chk(cmd_ready_o == (cnt < D), "R2 ready", cmd_ready_o, cnt < D);
    w = m_winner();
    chk(iss_valid_o == (w >= 0), "R3 valid", iss_valid_o, w >= 0);
    if (w >= 0 && iss_valid_o) begin
      chk(iss_id_o == m_id[w], cur_req, iss_id_o, m_id[w]);
      chk(iss_addr_o == m_addr[w] && iss_wr_o == m_wr[w] && iss_qos_o == m_qos[w],
          "R3 fields", iss_addr_o, m_addr[w]);
    end
    acc = push && (cnt < D);
    @(posedge clk);
    if (rdy && w >= 0) m_v[w] = 0;
    for (int i = 0; i < D; i++)
      if (m_v[i]) m_age[i] = (m_age[i] + int'(age_step_i) > 255) ? 255 : m_age[i] + int'(age_step_i);
    if (acc)
      for (int i = 0; i < D; i++)
        if (!m_v[i]) begin
          m_v[i] = 1; m_seq[i] = seq_n++; m_age[i] = 0;
          m_addr[i] = addr; m_wr[i] = wr; m_qos[i] = qos; m_id[i] = id;
          break;
        end
  endtask

  task automatic drain();
    for (int k = 0; k < 40 && m_count() > 0; k++) cyc(0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < D; i++) m_v[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk(iss_valid_o == 0, "R1 valid", iss_valid_o, 0);
    chk(cmd_ready_o == 1, "R1 ready", cmd_ready_o, 1);
    rst_ni = 1'b1;
    @(posedge clk);
    #1;
    chk(iss_valid_o == 0 && cmd_ready_o == 1, "R1 after release", iss_valid_o, 0);

    // R2 fill past depth, then R6 drain in arrival order
    cur_req = "R6";
    for (int k = 0; k < 10; k++) cyc(1, 0, 16'(k * 64), 0, 4'(k), 0);
    chk(cmd_ready_o == 0, "R2 full", cmd_ready_o, 0);
    drain();

    // R4 read before older write
    cur_req = "R4";
    cyc(1, 1, 16'h0040, 1, 4'h1, 0);
    cyc(1, 0, 16'h0080, 1, 4'h2, 0);
    cyc(0, 0, 0, 0, 0, 0);
    chk(iss_id_o == 4'h2, "R4 read first", iss_id_o, 2);
    drain();

    // R4 write waits behind read stream with step 0
    cyc(1, 1, 16'h0100, 0, 4'h7, 1);
    for (int k = 0; k < 12; k++) cyc(1, 0, 16'(16'h0200 + k * 64), 0, 4'(k), 1);
    drain();

    // R5 higher QoS beats read preference
    cur_req = "R5";
    cyc(1, 0, 16'h0400, 0, 4'h3, 0);
    cyc(1, 1, 16'h0440, 3, 4'h4, 0);
    cyc(0, 0, 0, 0, 0, 0);
    chk(iss_id_o == 4'h4, "R5 qos first", iss_id_o, 4);
    drain();

    // R7 aged write outranks high-QoS read
    cur_req = "R7";
    age_step_i = 8'd16; age_limit_i = 8'd32;
    cyc(1, 1, 16'h0800, 0, 4'h5, 0);
    cyc(0, 0, 0, 0, 0, 0);
    cyc(1, 0, 16'h0840, 3, 4'h6, 0);
    cyc(0, 0, 0, 0, 0, 0);
    chk(iss_id_o == 4'h5, "R7 aged first", iss_id_o, 5);
    drain();
    // R7 saturation reaches limit 255
    age_step_i = 8'd200; age_limit_i = 8'd255;
    cyc(1, 1, 16'h0900, 0, 4'h8, 0);
    cyc(0, 0, 0, 0, 0, 0);
    cyc(1, 0, 16'h0940, 3, 4'h9, 0);
    cyc(0, 0, 0, 0, 0, 0);
    chk(iss_id_o == 4'h8, "R7 saturated aged", iss_id_o, 8);
    drain();
    age_step_i = 8'd0;

    // R8 same-line read held behind write
    cur_req = "R8";
    cyc(1, 1, 16'h1400, 0, 4'hA, 0);
    cyc(1, 0, 16'h1408, 3, 4'hB, 0);
    cyc(1, 0, 16'h1800, 0, 4'hC, 0);
    cyc(0, 0, 0, 0, 0, 0);
    chk(iss_id_o == 4'hC, "R8 other line first", iss_id_o, 12);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0);
    chk(iss_id_o == 4'hA, "R8 write before held read", iss_id_o, 10);
    drain();

    // R9 zero limit gives arrival order
    cur_req = "R9";
    age_limit_i = 8'd0;
    cyc(1, 1, 16'h2000, 0, 4'h1, 0);
    cyc(1, 0, 16'h2040, 3, 4'h2, 0);
    cyc(1, 1, 16'h2080, 1, 4'h3, 0);
    cyc(0, 0, 0, 0, 0, 0);
    chk(iss_id_o == 4'h1, "R9 oldest", iss_id_o, 1);
    drain();

    // R10 offer held while stalled
    cur_req = "R10";
    age_limit_i = 8'd255;
    cyc(1, 0, 16'h3000, 2, 4'hD, 0);
    for (int k = 0; k < 4; k++) begin
      cyc(0, 0, 0, 0, 0, 0);
      chk(iss_valid_o == 1, "R10 hold", iss_valid_o, 1);
    end
    drain();

    // random phases
    cur_req = "R3 R4 R5 R6 R7 R8 mix";
    for (int p = 0; p < 6; p++) begin
      age_step_i  = 8'($urandom_range(0, 40));
      age_limit_i = 8'($urandom_range(0, 255));
      for (int k = 0; k < 600; k++)
        cyc($urandom_range(0, 99) < 60, $urandom_range(0, 1) == 1,
            16'({$urandom_range(0, 3), 6'($urandom)}), 2'($urandom), 4'($urandom),
            $urandom_range(0, 99) < 45);
      drain();
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule